// File: doc/BRIEF.md
# Stacked Register Frame Renamer

This block translates logical general-register numbers into physical register numbers for a procedure register stack. The lowest 32 logical registers are fixed and map to the same physical number. The logical registers from 32 to 127 name slots of the current procedure frame. Those slots live in a circular pool of 96 physical registers, found by adding a frame base pointer and wrapping around the pool.

The block holds a frame descriptor made of a base pointer, a total frame size and a local-part size. Software or a sequencer resizes the current frame with an allocate command that gives a local count and an output count. A call command saves the descriptor on an eight-entry stack and slides the base past the caller's locals, so the caller's outputs become the callee's registers from logical 32 upward. No data is copied. A return command restores the saved descriptor. Errors and a spill request are reported as one-cycle pulses. The spill request means older frames must be written out to memory. That memory traffic, and the register file itself, sit outside this block.

Top module: `frame_renamer`

## Requirements
- R1: A lookup index below 32 gives a physical index equal to the lookup index, with lookupValid high, in the same cycle.
- R2: A lookup index r of 32 or more gives physical index 32 + ((base + r - 32) mod 96), computed combinationally from the descriptor now held. lookupValid is high only when r - 32 is less than the frame size.
- R3: After reset, base, frame size and local size are 0, all pulse outputs are low and the saved-descriptor stack is empty.
- R4: An accepted allocate with locals + outputs of 96 or less sets frame size to locals + outputs and local size to locals on the next clock edge. The base is left unchanged.
- R5: An allocate with locals + outputs above 96 raises allocErr for one cycle and leaves the descriptor and the stack unchanged.
- R6: An accepted call pushes the descriptor. It then sets base to (base + local size) mod 96, frame size to the old frame size minus the old local size, and local size to 0.
- R7: A call while 8 descriptors are saved raises overflowErr for one cycle and changes nothing.
- R8: A return pops the last saved descriptor and restores base, frame size and local size on one edge. A return with the stack empty raises underflowErr for one cycle and changes nothing.
- R9: Registers in use is the sum of the local sizes of all saved descriptors plus the current frame size. An accepted allocate that would make this exceed 96 raises spillReq for one cycle, and the allocation still takes effect.
- R10: When commands coincide, allocate wins over call and call wins over return. A command that loses is ignored completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocEn | input | 1 | Allocate command strobe |
| allocLocals | input | 7 | Local count for allocate |
| allocOutputs | input | 7 | Output count for allocate |
| callEn | input | 1 | Call command strobe |
| retEn | input | 1 | Return command strobe |
| lookupIdx | input | 7 | Logical register number to translate |
| physIdx | output | 7 | Physical register number |
| lookupValid | output | 1 | Logical number lies inside the map |
| curBase | output | 7 | Current frame base pointer |
| curSize | output | 7 | Current frame size |
| curLocals | output | 7 | Current local size |
| allocErr | output | 1 | Oversized allocate rejected (pulse) |
| overflowErr | output | 1 | Call with full descriptor stack (pulse) |
| underflowErr | output | 1 | Return with empty descriptor stack (pulse) |
| spillReq | output | 1 | Pool over-committed, spill needed (pulse) |

## Verification
Two cases can share a cycle: a lookup and a command that moves the frame, or two commands together. The bench holds a stacked lookup index steady while a call is asserted. It expects the old mapping before the clock edge and the slid mapping after it. For coinciding commands, the bench asserts allocate together with call, and call together with return. It then shows that the losing command left no trace: a later return must underflow, or the restored descriptor must match the earlier frame.

// File: rtl/frame_renamer_pkg.sv
package frame_renamer_pkg;
  localparam int unsigned IDX_W       = 7;
  localparam int unsigned STATIC_REGS = 32;
  localparam int unsigned POOL_SIZE   = 96;

  typedef struct packed {
    logic doAlloc;
    logic doCall;
    logic doRet;
  } frameStrobe_t;

  typedef struct packed {
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] size;
    logic [IDX_W-1:0] locals;
  } frameMark_t;
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_renamer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         allocEn,
  input  logic         callEn,
  input  logic         retEn,
  input  logic         allocTooBig,
  input  logic         spillHint,
  input  logic         stackEmpty,
  input  logic         stackFull,
  output frameStrobe_t strobe,
  output logic         allocErr,
  output logic         overflowErr,
  output logic         underflowErr,
  output logic         spillReq
);
  logic selAlloc, selCall, selRet;

  // allocate beats call, call beats return
  always_comb begin
    selAlloc       = allocEn;
    selCall        = callEn && !allocEn;
    selRet         = retEn && !allocEn && !callEn;
    strobe.doAlloc = selAlloc && !allocTooBig;
    strobe.doCall  = selCall && !stackFull;
    strobe.doRet   = selRet && !stackEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocErr     <= 1'b0;
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
      spillReq     <= 1'b0;
    end else begin
      allocErr     <= selAlloc && allocTooBig;
      overflowErr  <= selCall && stackFull;
      underflowErr <= selRet && stackEmpty;
      spillReq     <= strobe.doAlloc && spillHint;
    end
  end
endmodule

// File: rtl/frame_dp.sv
module frame_dp
  import frame_renamer_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  frameStrobe_t     strobe,
  input  logic [IDX_W-1:0] allocLocals,
  input  logic [IDX_W-1:0] allocOutputs,
  input  logic [IDX_W-1:0] lookupIdx,
  output logic [IDX_W-1:0] physIdx,
  output logic             lookupValid,
  output logic             allocTooBig,
  output logic             spillHint,
  output logic             stackEmpty,
  output logic             stackFull,
  output frameMark_t       curMark
);
  localparam int unsigned PTR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(STACK_DEPTH + 1);
  localparam int unsigned SUM_W = $clog2(POOL_SIZE * (STACK_DEPTH + 1) + 1);
  localparam logic [IDX_W:0]   POOL_W   = (IDX_W+1)'(POOL_SIZE);
  localparam logic [SUM_W-1:0] POOL_S   = SUM_W'(POOL_SIZE);
  localparam logic [IDX_W-1:0] STATIC_I = IDX_W'(STATIC_REGS);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(STACK_DEPTH);

  frameMark_t       saved [STACK_DEPTH];
  logic [CNT_W-1:0] depth;
  logic [SUM_W-1:0] lockedSum;
  logic [PTR_W-1:0] pushPtr, popPtr;
  logic [IDX_W:0]   allocTotal;
  frameMark_t       popMark;

  function automatic logic [IDX_W:0] wrapPool(input logic [IDX_W:0] s);
    return (s >= POOL_W) ? (s - POOL_W) : s;
  endfunction

  assign pushPtr    = PTR_W'(depth);
  assign popPtr     = PTR_W'(depth - 1'b1);
  assign popMark    = saved[popPtr];
  assign stackEmpty = (depth == '0);
  assign stackFull  = (depth == DEPTH_C);
  assign allocTotal = {1'b0, allocLocals} + {1'b0, allocOutputs};
  assign allocTooBig = (allocTotal > POOL_W);
  assign spillHint  = (lockedSum + SUM_W'(allocTotal)) > POOL_S;

  // logical to physical translation
  logic [IDX_W-1:0] offs;
  logic [IDX_W:0]   slot;
  always_comb begin
    offs = lookupIdx - STATIC_I;
    slot = wrapPool({1'b0, curMark.base} + {1'b0, offs});
    if (lookupIdx < STATIC_I) begin
      physIdx     = lookupIdx;
      lookupValid = 1'b1;
    end else begin
      physIdx     = STATIC_I + slot[IDX_W-1:0];
      lookupValid = (offs < curMark.size);
    end
  end

  // descriptor and stack control state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMark   <= '0;
      depth     <= '0;
      lockedSum <= '0;
    end else if (strobe.doAlloc) begin
      curMark.size   <= allocTotal[IDX_W-1:0];
      curMark.locals <= allocLocals;
    end else if (strobe.doCall) begin
      curMark.base   <= IDX_W'(wrapPool({1'b0, curMark.base} + {1'b0, curMark.locals}));
      curMark.size   <= curMark.size - curMark.locals;
      curMark.locals <= '0;
      depth          <= depth + 1'b1;
      lockedSum      <= lockedSum + SUM_W'(curMark.locals);
    end else if (strobe.doRet) begin
      curMark   <= popMark;
      depth     <= depth - 1'b1;
      lockedSum <= lockedSum - SUM_W'(popMark.locals);
    end
  end

  // saved descriptor storage, one write port per entry
  for (genvar g = 0; g < STACK_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.doCall && (pushPtr == PTR_W'(g)))
        saved[g] <= curMark;
    end
  end
endmodule

// File: rtl/frame_renamer.sv
module frame_renamer
  import frame_renamer_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocEn,
  input  logic [IDX_W-1:0] allocLocals,
  input  logic [IDX_W-1:0] allocOutputs,
  input  logic             callEn,
  input  logic             retEn,
  input  logic [IDX_W-1:0] lookupIdx,
  output logic [IDX_W-1:0] physIdx,
  output logic             lookupValid,
  output logic [IDX_W-1:0] curBase,
  output logic [IDX_W-1:0] curSize,
  output logic [IDX_W-1:0] curLocals,
  output logic             allocErr,
  output logic             overflowErr,
  output logic             underflowErr,
  output logic             spillReq
);
  frameStrobe_t strobe;
  frameMark_t   curMark;
  logic allocTooBig, spillHint, stackEmpty, stackFull;

  frame_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .allocEn(allocEn), .callEn(callEn), .retEn(retEn),
    .allocTooBig(allocTooBig), .spillHint(spillHint),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .strobe(strobe),
    .allocErr(allocErr), .overflowErr(overflowErr),
    .underflowErr(underflowErr), .spillReq(spillReq)
  );

  frame_dp #(.STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocLocals(allocLocals), .allocOutputs(allocOutputs),
    .lookupIdx(lookupIdx), .physIdx(physIdx), .lookupValid(lookupValid),
    .allocTooBig(allocTooBig), .spillHint(spillHint),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .curMark(curMark)
  );

  assign curBase   = curMark.base;
  assign curSize   = curMark.size;
  assign curLocals = curMark.locals;
endmodule

// File: rtl/frame_renamer_chk.sv
module frame_renamer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       allocEn,
  input logic [6:0] allocLocals,
  input logic [6:0] allocOutputs,
  input logic       callEn,
  input logic       retEn,
  input logic [6:0] lookupIdx,
  input logic [6:0] physIdx,
  input logic       lookupValid,
  input logic [6:0] curBase,
  input logic [6:0] curSize,
  input logic [6:0] curLocals,
  input logic       allocErr,
  input logic       overflowErr,
  input logic       underflowErr,
  input logic       spillReq
);
  a_r1_static_pass: assert property (@(posedge clk) disable iff (!rstN)
    (lookupIdx < 7'd32) |-> (physIdx == lookupIdx && lookupValid));

  a_r2_stacked_range: assert property (@(posedge clk) disable iff (!rstN)
    (lookupIdx >= 7'd32) |-> (physIdx >= 7'd32));

  a_r5_alloc_err_keeps: assert property (@(posedge clk) disable iff (!rstN)
    allocErr |-> (curBase == $past(curBase) && curSize == $past(curSize)
                  && curLocals == $past(curLocals)));

  a_r6_call_slides: assert property (@(posedge clk) disable iff (!rstN)
    (callEn && !allocEn) |=> (overflowErr ||
      (curLocals == 7'd0 && curSize == $past(curSize) - $past(curLocals))));

  a_r7_overflow_keeps: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |-> (curBase == $past(curBase) && curSize == $past(curSize)));

  a_r8_underflow_keeps: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |-> (curBase == $past(curBase) && curSize == $past(curSize)
                      && curLocals == $past(curLocals)));

  a_r10_one_error: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({allocErr, overflowErr, underflowErr}));

  a_r4_size_bound: assert property (@(posedge clk) disable iff (!rstN)
    (curSize <= 7'd96 && curLocals <= curSize && curBase < 7'd96));
endmodule

bind frame_renamer frame_renamer_chk u_chk (.*);

// File: tb/sim_frame_renamer.sv
`timescale 1ns/1ps
module sim_frame_renamer;
  logic clk = 1'b0, rstN = 1'b0;
  logic allocEn = 0, callEn = 0, retEn = 0;
  logic [6:0] allocLocals = 0, allocOutputs = 0, lookupIdx = 0;
  logic [6:0] physIdx, curBase, curSize, curLocals;
  logic lookupValid, allocErr, overflowErr, underflowErr, spillReq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  frame_renamer u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one command for one edge, then sample after that edge
  task automatic cmd(input bit a, input int l, input int o, input bit c, input bit r);
    @(negedge clk);
    allocEn = a; allocLocals = 7'(l); allocOutputs = 7'(o); callEn = c; retEn = r;
    @(negedge clk);
    allocEn = 0; callEn = 0; retEn = 0;
    #1;
  endtask

  task automatic look(input string req, input int idx, input int expP, input bit expV);
    lookupIdx = 7'(idx); #1;
    chk(req, lookupValid, expV);
    if (expV) chk(req, physIdx, expP);
  endtask

  task automatic mark(input string req, input int b, input int s, input int l);
    chk({req, " base"}, curBase, b);
    chk({req, " size"}, curSize, s);
    chk({req, " locals"}, curLocals, l);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1; #1;
  endtask

  task automatic t_reset();   // R3, R1
    doReset();
    mark("R3", 0, 0, 0);
    chk("R3 errs", {allocErr, overflowErr, underflowErr, spillReq}, 0);
    look("R1", 5, 5, 1);
    look("R1", 31, 31, 1);
    look("R2 empty frame", 32, 0, 0);
  endtask

  task automatic t_alloc_call_ret();  // R4 R6 R2 R9 R5 R8
    doReset();
    cmd(1, 10, 6, 0, 0);
    mark("R4", 0, 16, 10);
    look("R2", 32, 32, 1);
    look("R2", 47, 47, 1);
    look("R2 edge", 48, 0, 0);
    cmd(0, 0, 0, 1, 0);
    mark("R6", 10, 6, 0);
    look("R6 map", 32, 42, 1);
    look("R6 map", 37, 47, 1);
    look("R6 edge", 38, 0, 0);
    cmd(1, 90, 0, 0, 0);
    chk("R9 spill", spillReq, 1);
    mark("R9 applied", 10, 90, 90);
    look("R2 top", 117, 127, 1);
    look("R2 wrap", 118, 32, 1);
    cmd(1, 50, 47, 0, 0);
    chk("R5 err", allocErr, 1);
    mark("R5 keep", 10, 90, 90);
    cmd(1, 50, 46, 0, 0);
    chk("R5 limit ok", allocErr, 0);
    chk("R9 spill", spillReq, 1);
    cmd(1, 4, 2, 0, 0);
    chk("R9 no spill", spillReq, 0);
    cmd(0, 0, 0, 0, 1);
    mark("R8 restore", 0, 16, 10);
    chk("R8 no err", underflowErr, 0);
    cmd(0, 0, 0, 0, 1);
    chk("R8 underflow", underflowErr, 1);
    mark("R8 keep", 0, 16, 10);
  endtask

  task automatic t_overflow();  // R7 R8
    doReset();
    for (int i = 0; i < 8; i++) begin
      cmd(1, 4, 4, 0, 0);
      cmd(0, 0, 0, 1, 0);
    end
    mark("R7 deep", 32, 4, 0);
    cmd(1, 4, 4, 0, 0);
    cmd(0, 0, 0, 1, 0);
    chk("R7 overflow", overflowErr, 1);
    mark("R7 keep", 32, 8, 4);
    for (int i = 0; i < 8; i++) cmd(0, 0, 0, 0, 1);
    mark("R8 bottom", 0, 8, 4);
    chk("R8 no err", underflowErr, 0);
    cmd(0, 0, 0, 0, 1);
    chk("R8 underflow", underflowErr, 1);
  endtask

  task automatic t_priority();  // R10
    doReset();
    cmd(1, 8, 8, 1, 0);
    mark("R10 alloc wins", 0, 16, 8);
    cmd(0, 0, 0, 0, 1);
    chk("R10 call ignored", underflowErr, 1);
    cmd(0, 0, 0, 1, 1);
    mark("R10 call wins", 8, 8, 0);
    cmd(0, 0, 0, 0, 1);
    mark("R10 ret ignored", 0, 16, 8);
    chk("R10 stack", underflowErr, 0);
  endtask

  task automatic t_lookup_during_call();  // R2 R6
    doReset();
    cmd(1, 20, 5, 0, 0);
    @(negedge clk);
    lookupIdx = 7'd33; callEn = 1; #1;
    chk("R2 before edge", physIdx, 33);
    @(negedge clk);
    callEn = 0; #1;
    chk("R6 after edge", physIdx, 53);
    chk("R6 valid", lookupValid, 1);
  endtask

  initial begin
    t_reset();
    t_alloc_call_ret();
    t_overflow();
    t_priority();
    t_lookup_during_call();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule